// File: doc/BRIEF.md
# SD SPI Command Issuer

This block issues a single SD-card command over an SPI link and hands back the card's one-byte R1 reply. It sits between a host-side controller and a byte-wide SPI exchange engine. The controller pulses `start` with a 6-bit command index, a 32-bit argument and a limit on how long to wait for the card. The block first makes sure the card has stopped signalling busy. It then clocks out the six-byte command frame and polls for the reply. It finishes with a one-cycle `cmd_done` pulse.

Every byte the block moves goes through a full-duplex request/acknowledge exchange. While `xfer_req` is high, `xfer_tx` carries the byte to shift out. The cycle in which `xfer_ack` is high completes the exchange, and `xfer_rx` holds the byte the card returned in that cycle. Chip-select handling, data-block phases and card initialisation belong to neighbouring blocks.

Top module: `sdspi_cmd_issuer`

## Requirements
- R1: The first frame byte is binary 01 followed by the 6-bit command index, i.e. 0x40 + index.
- R2: Frame bytes two to five carry the 32-bit argument, bits 31:24 first and bits 7:0 last.
- R3: The sixth frame byte is always 0x95, whatever the command.
- R4: Before the frame, one 0xFF byte is exchanged and its reply discarded. After that, 0xFF is exchanged repeatedly until the card returns 0xFF, and the frame begins only after that 0xFF arrives.
- R5: For command index 12 only, one further 0xFF exchange follows the frame and its reply is discarded, even when that reply has bit 7 clear.
- R6: Response polling sends 0xFF. The first reply with bit 7 clear ends the command, becomes `cmd_resp`, and leaves `cmd_fail` low.
- R7: After 10 polling exchanges without a bit-7-clear reply, the block stops, returns the tenth reply in `cmd_resp` and raises `cmd_fail`.
- R8: When `ready_limit` consecutive ready-wait replies (a limit of 0 acts as 1) are all other than 0xFF, the block ends with `cmd_resp` = 0xFF and `cmd_fail` high, and sends no frame byte.
- R9: `cmd_done` is high for exactly one cycle per command. `cmd_resp` and `cmd_fail` are valid in that cycle and hold until the next command finishes.
- R10: A `start` pulse while a command is in progress, including the `cmd_done` cycle, is ignored and does not change the command being sent.
- R11: While `xfer_req` is high and `xfer_ack` is low, `xfer_req` stays high and `xfer_tx` stays unchanged. Each acknowledged cycle completes exactly one byte.
- R12: After reset `xfer_req` and `cmd_done` are low, `cmd_resp` is 0xFF and `cmd_fail` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| ready_limit | input | LIMIT_W | Maximum ready-wait exchanges (0 acts as 1) |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_resp | output | 8 | Response byte |
| cmd_fail | output | 1 | Ready timeout or no valid response |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Exchange complete this cycle |
| xfer_rx | input | 8 | Byte shifted in, valid with `xfer_ack` |

## Verification
The command path is driven with several card reply scripts:
- A card that is ready at once against one that stays busy for a few bytes, which separates the flush byte from the ready loop.
- A ready reply arriving exactly at the limit against one that never arrives. These pin down the off-by-one edge of the timeout, and a limit of zero is also covered.
- A stop-transmission command whose stuff byte looks like a valid reply, which shows whether that byte is really discarded.
- Replies valid at the tenth poll, invalid at the tenth poll and never valid, which bound the poll window from both sides.

Acknowledge latencies vary from byte to byte to exercise the handshake. A second `start` is injected mid-command to show that it is ignored.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FLUSH, ST_WAIT, ST_SEND, ST_SKIP, ST_POLL, ST_DONE
  } phase_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] FIXED_CRC = 8'h95;
  localparam logic [5:0] STOP_IDX  = 6'd12;
  localparam int         FRAME_LEN = 6;

  // Byte at position slot of the six-byte command frame
  function automatic logic [7:0] frame_byte(input logic [5:0] idx,
                                            input logic [31:0] arg,
                                            input logic [2:0] slot);
    case (slot)
      3'd0:    return {2'b01, idx};
      3'd1:    return arg[31:24];
      3'd2:    return arg[23:16];
      3'd3:    return arg[15:8];
      3'd4:    return arg[7:0];
      default: return FIXED_CRC;
    endcase
  endfunction

  // True when used exchanges reach the limit; a zero limit counts as one
  function automatic logic wait_exhausted(input logic [31:0] used,
                                          input logic [31:0] limit);
    logic [31:0] eff;
    eff = (limit == 32'd0) ? 32'd1 : limit;
    return used >= eff;
  endfunction

endpackage

// File: rtl/sdcmd_count.sv
module sdcmd_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sdcmd_frame.sv
module sdcmd_frame
  import sdcmd_pkg::*;
(
  input  logic        in_send,
  input  logic [2:0]  slot,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  output logic [7:0]  tx
);

  always_comb tx = in_send ? frame_byte(idx, arg, slot) : FILL_BYTE;

endmodule

// File: rtl/sdspi_cmd_issuer.sv
module sdspi_cmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int LIMIT_W    = 16,
  parameter int POLL_TRIES = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [5:0]         cmd_idx,
  input  logic [31:0]        cmd_arg,
  input  logic [LIMIT_W-1:0] ready_limit,
  output logic               cmd_done,
  output logic [7:0]         cmd_resp,
  output logic               cmd_fail,
  output logic               xfer_req,
  output logic [7:0]         xfer_tx,
  input  logic               xfer_ack,
  input  logic [7:0]         xfer_rx
);

  localparam int STEP_W = ($clog2(POLL_TRIES) > 2) ? $clog2(POLL_TRIES) + 1 : 3;
  localparam logic [STEP_W-1:0] LAST_SLOT = STEP_W'(FRAME_LEN - 1);
  localparam logic [STEP_W-1:0] LAST_POLL = STEP_W'(POLL_TRIES - 1);

  phase_t st, st_d;
  logic [5:0]         idx_q;
  logic [31:0]        arg_q;
  logic [LIMIT_W-1:0] lim_q;
  logic [LIMIT_W-1:0] wait_cnt;
  logic [STEP_W-1:0]  step;
  logic [2:0]         slot;

  // Named internal events
  logic busy, xfer_done, phase_change;
  logic in_wait, in_send, in_skip, in_poll;
  logic ev_card_ready, ev_ready_timeout, ev_frame_end, ev_resp_ok, ev_poll_giveup;

  assign busy      = (st != ST_IDLE);
  assign xfer_req  = (st != ST_IDLE) && (st != ST_DONE);
  assign xfer_done = xfer_req && xfer_ack;
  assign in_wait   = (st == ST_WAIT);
  assign in_send   = (st == ST_SEND);
  assign in_skip   = (st == ST_SKIP);
  assign in_poll   = (st == ST_POLL);
  assign slot      = step[2:0];

  assign ev_card_ready    = xfer_done && in_wait && (xfer_rx == FILL_BYTE);
  assign ev_ready_timeout = xfer_done && in_wait && (xfer_rx != FILL_BYTE) &&
                            wait_exhausted(32'(wait_cnt) + 32'd1, 32'(lim_q));
  assign ev_frame_end     = xfer_done && in_send && (step == LAST_SLOT);
  assign ev_resp_ok       = xfer_done && in_poll && !xfer_rx[7];
  assign ev_poll_giveup   = xfer_done && in_poll && xfer_rx[7] && (step == LAST_POLL);

  always_comb begin
    st_d = st;
    case (st)
      ST_IDLE:  if (start) st_d = ST_FLUSH;
      ST_FLUSH: if (xfer_done) st_d = ST_WAIT;
      ST_WAIT:  if (ev_card_ready) st_d = ST_SEND;
                else if (ev_ready_timeout) st_d = ST_DONE;
      ST_SEND:  if (ev_frame_end) st_d = (idx_q == STOP_IDX) ? ST_SKIP : ST_POLL;
      ST_SKIP:  if (xfer_done) st_d = ST_POLL;
      ST_POLL:  if (ev_resp_ok || ev_poll_giveup) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign phase_change = (st_d != st);

  // Byte position within the frame or polling window
  sdcmd_count #(.W(STEP_W)) u_step (
    .clk(clk), .rst_n(rst_n), .clr(phase_change), .inc(xfer_done), .cnt(step)
  );

  // Ready-wait exchanges so far
  sdcmd_count #(.W(LIMIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(phase_change), .inc(xfer_done && in_wait),
    .cnt(wait_cnt)
  );

  sdcmd_frame u_frame (
    .in_send(in_send), .slot(slot), .idx(idx_q), .arg(arg_q), .tx(xfer_tx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx_q    <= '0;
      arg_q    <= '0;
      lim_q    <= '0;
      cmd_resp <= FILL_BYTE;
      cmd_fail <= 1'b0;
    end else begin
      st <= st_d;
      if (st == ST_IDLE && start) begin
        idx_q <= cmd_idx;
        arg_q <= cmd_arg;
        lim_q <= ready_limit;
      end
      if (ev_ready_timeout) begin
        cmd_resp <= FILL_BYTE;
        cmd_fail <= 1'b1;
      end else if (ev_resp_ok || ev_poll_giveup) begin
        cmd_resp <= xfer_rx;
        cmd_fail <= ev_poll_giveup;
      end
    end
  end

  assign cmd_done = (st == ST_DONE);

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       cmd_done,
  input logic       cmd_fail,
  input logic [7:0] cmd_resp,
  input logic       xfer_req,
  input logic       xfer_ack,
  input logic [7:0] xfer_tx,
  input logic [5:0] idx_q,
  input logic       in_send,
  input logic       in_skip,
  input logic       in_poll,
  input logic [2:0] slot,
  input logic       ev_frame_end,
  input logic       ev_ready_timeout,
  input logic       ev_resp_ok,
  input logic       ev_poll_giveup
);

  a_r11_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  a_r9_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !xfer_req);

  a_r1_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && in_send && slot == 3'd0 |-> xfer_tx == {2'b01, idx_q});

  a_r3_crc: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && in_send && slot == 3'd5 |-> xfer_tx == 8'h95);

  a_r5_stuff: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end && idx_q == 6'd12 |=> in_skip);

  a_r5_no_stuff: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end && idx_q != 6'd12 |=> in_poll);

  a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready_timeout |=> cmd_done && cmd_fail && cmd_resp == 8'hFF);

  a_r7_giveup: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poll_giveup |=> cmd_done && cmd_fail && cmd_resp[7]);

  a_r6_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_ok |=> cmd_done && !cmd_fail && !cmd_resp[7]);

  a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(idx_q));

endmodule

bind sdspi_cmd_issuer sdcmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .cmd_done(cmd_done), .cmd_fail(cmd_fail), .cmd_resp(cmd_resp),
  .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_tx(xfer_tx),
  .idx_q(idx_q), .in_send(in_send), .in_skip(in_skip), .in_poll(in_poll),
  .slot(slot), .ev_frame_end(ev_frame_end), .ev_ready_timeout(ev_ready_timeout),
  .ev_resp_ok(ev_resp_ok), .ev_poll_giveup(ev_poll_giveup)
);

// File: tb/sdspi_cmd_issuer_test.sv
`timescale 1ns/1ps
module sdspi_cmd_issuer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [15:0] ready_limit = '0;
  logic        cmd_done, cmd_fail, xfer_req;
  logic [7:0]  cmd_resp, xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'h00;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  sdspi_cmd_issuer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .ready_limit(ready_limit), .cmd_done(cmd_done),
    .cmd_resp(cmd_resp), .cmd_fail(cmd_fail), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: expected byte stream and result from a card script
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input int lim, input logic [7:0] scr[$], input bit poke);
    logic [7:0] card[$];
    logic [7:0] etx[$];
    string      etag[$];
    logic [7:0] b;
    logic [7:0] eresp;
    bit         efail;
    bit         ready;
    int         n;
    int         g;
    card = scr;
    b = (card.size() > 0) ? card.pop_front() : 8'hFF;
    etx.push_back(8'hFF); etag.push_back("R4");
    n = 0; ready = 0;
    while (1) begin
      etx.push_back(8'hFF); etag.push_back("R4");
      b = (card.size() > 0) ? card.pop_front() : 8'hFF;
      n++;
      if (b == 8'hFF) begin ready = 1; break; end
      if (n >= ((lim == 0) ? 1 : lim)) break;
    end
    if (!ready) begin
      eresp = 8'hFF; efail = 1;
    end else begin
      etx.push_back(8'h40 + 8'(idx)); etag.push_back("R1");
      for (int k = 3; k >= 0; k--) begin
        etx.push_back(arg[k*8 +: 8]); etag.push_back("R2");
      end
      etx.push_back(8'h95); etag.push_back("R3");
      for (int k = 0; k < 6; k++) b = (card.size() > 0) ? card.pop_front() : 8'hFF;
      if (idx == 6'd12) begin
        etx.push_back(8'hFF); etag.push_back("R5");
        b = (card.size() > 0) ? card.pop_front() : 8'hFF;
      end
      eresp = 8'hFF; efail = 1;
      for (int k = 0; k < 10; k++) begin
        etx.push_back(8'hFF); etag.push_back("R6");
        b = (card.size() > 0) ? card.pop_front() : 8'hFF;
        eresp = b; efail = b[7];
        if (!b[7]) break;
      end
    end

    // Drive the command
    cmd_idx = idx; cmd_arg = arg; ready_limit = 16'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    card = scr;
    for (int i = 0; i < etx.size(); i++) begin
      g = 0;
      while (!xfer_req && g < 20) begin @(negedge clk); g++; end
      if (!xfer_req) begin
        chk(0, "R11", "request missing", 0, 1);
        return;
      end
      for (int d = 0; d < (i % 3); d++) begin
        @(negedge clk);
        chk(xfer_req === 1'b1, "R11", "request held", int'(xfer_req), 1);
      end
      chk(xfer_tx === etx[i], etag[i], $sformatf("tx byte %0d", i),
          int'(xfer_tx), int'(etx[i]));
      chk(cmd_done === 1'b0, "R9", "done early", int'(cmd_done), 0);
      xfer_ack = 1'b1;
      xfer_rx  = (card.size() > 0) ? card.pop_front() : 8'hFF;
      if (poke && i == 2) begin
        start = 1'b1; cmd_idx = ~idx; ready_limit = 16'd1;
      end
      @(negedge clk);
      xfer_ack = 1'b0;
      xfer_rx  = 8'h00;
      start = 1'b0; cmd_idx = idx;
    end
    chk(cmd_done === 1'b1, "R9", "done pulse", int'(cmd_done), 1);
    chk(cmd_resp === eresp, efail ? (ready ? "R7" : "R8") : "R6", "response",
        int'(cmd_resp), int'(eresp));
    chk(cmd_fail === efail, efail ? (ready ? "R7" : "R8") : "R6", "fail flag",
        int'(cmd_fail), int'(efail));
    chk(xfer_req === 1'b0, "R8", "no byte after end", int'(xfer_req), 0);
    if (poke) start = 1'b1;   // start during the done cycle is ignored too
    @(negedge clk);
    start = 1'b0;
    chk(cmd_done === 1'b0, "R9", "done one cycle", int'(cmd_done), 0);
    chk(cmd_resp === eresp, "R9", "response held", int'(cmd_resp), int'(eresp));
    @(negedge clk);
    chk(xfer_req === 1'b0, poke ? "R10" : "R9", "no restart", int'(xfer_req), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(xfer_req === 1'b0, "R12", "req after reset", int'(xfer_req), 0);
    chk(cmd_done === 1'b0, "R12", "done after reset", int'(cmd_done), 0);
    chk(cmd_resp === 8'hFF, "R12", "resp after reset", int'(cmd_resp), 8'hFF);
    chk(cmd_fail === 1'b0, "R12", "fail after reset", int'(cmd_fail), 0);

    // R1 R2 R3 R6: ready at once, reply on third poll
    run_cmd(6'd17, 32'h1234_5678, 8,
            '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
              8'hFF, 8'hFF, 8'h00}, 0);
    // R4 R10: busy card, second start injected while busy
    run_cmd(6'd0, 32'h0, 8,
            '{8'hAA, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00,
              8'h00, 8'h00, 8'h01}, 1);
    // R5: stuff byte looks valid but must be dropped
    run_cmd(6'd12, 32'h0, 8,
            '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
              8'h3F, 8'hFF, 8'h00}, 0);
    // R7: card never answers
    run_cmd(6'd18, 32'hA5C3_0F81, 8, '{8'h00, 8'hFF}, 0);
    // R7: tenth poll still invalid, its value is returned
    run_cmd(6'd24, 32'h0000_0200, 8,
            '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
              8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hC5}, 0);
    // R6 R1: valid reply exactly on tenth poll, top index
    run_cmd(6'd63, 32'hFFFF_FFFF, 8,
            '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
              8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h05}, 0);
    // R8: ready timeout after four busy bytes
    run_cmd(6'd9, 32'h0BAD_F00D, 4, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0);
    // R8: zero limit behaves as one
    run_cmd(6'd58, 32'h0, 0, '{8'h00, 8'h7F}, 0);
    // R4 R8: ready arrives exactly at the limit
    run_cmd(6'd1, 32'h4000_0000, 3,
            '{8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
              8'h00, 8'h00}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule